// File: doc/BRIEF.md
# Compare-Channel Timer

This block is a timer with one compare channel. A 16-bit up-counter advances once every (prescaler + 1) clock cycles. After it reaches the reload value it returns to zero and raises a one-cycle update strobe. One channel compares the counter with a compare value. It can drive its output pin as a pulse-width modulator in either polarity. It can also act as a match unit that toggles the pin, sets it, clears it, or only raises a match strobe.

Software programs the timer through a small write port. The prescaler, reload and compare values are held in staging registers. They move into the working registers only at a wrap, or at any time while the counter is stopped, so the waveform never changes partway through a period. In one-shot operation the counter waits at zero for a trigger input. It then counts once up to the reload value and stops by itself, which gives a single pulse: the compare value sets its delay and the reload value sets its end.

Top module: `cmp_timer`

## Requirements
- R1: The write port uses address 0 for control, 1 for the prescaler, 2 for the reload value and 3 for the compare value. The control fields are: bit 0 enables counting, bits 3:1 select the mode, and bit 4 selects one-shot. While enabled, the counter spends (prescaler+1) cycles on each value from 0 up to the reload value, so a period is (reload+1)(prescaler+1) cycles. `upd_evt` is high for exactly the cycle in which the counter has just wrapped to 0.
- R2: Mode 6, PWM with active-low region: `ch_out` is high while the counter is below the compare value. If the compare value exceeds the reload value, the pin stays high for the whole period. If the compare value is 0, the pin never goes high.
- R3: Mode 7, inverted PWM: `ch_out` is high while the counter is at or above the compare value.
- R4: Mode 3 inverts `ch_out` on every compare match, so the pin pattern repeats every two periods and is high for half of them in total.
- R5: Mode 1 sets `ch_out` high on a match and mode 2 clears it on a match. Between matches the pin keeps its value, including across a mode change.
- R6: Mode 0 never changes `ch_out`, which stays low after enabling, but it still raises `cmp_evt` on every match.
- R7: `cmp_evt` is high for one cycle, in the cycle after the counter has advanced onto the compare value. Over a run of whole periods there is one strobe per period for any prescaler setting.
- R8: Writes to the prescaler, reload and compare values while the counter runs have no effect until the next wrap.
- R9: With one-shot set and the timer enabled, the counter stays at 0 and no strobes occur until `trig` is seen high on a clock edge. The counter then runs a single pass to the reload value, returns to 0 and halts. In mode 7 this yields one pulse, high for counter values from the compare value up to the reload value.
- R10: During reset and after it, before anything is written, `ch_out`, `cmp_evt` and `upd_evt` are low. Disabling the timer forces `ch_out` low and returns the counter to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| trig | input | 1 | Start request for one-shot operation |
| ch_out | output | 1 | Channel output pin |
| cmp_evt | output | 1 | Compare-match strobe |
| upd_evt | output | 1 | Wrap (update) strobe |

## Verification
Some properties are checked on every cycle:
- the counter never passes the working reload value;
- both strobes fall only on counter values of 0 or the compare value;
- in mode 6 the pin rises only at the start of a period;
- in modes 0 and 1 the pin never falls or changes;
- an idle one-shot counter stays at 0.

Other behaviour shows only across the bench's whole-period scenarios. This covers the exact high-cycle totals for each mode and prescaler setting, the halved toggle rate, and deferred writes changing the next period but not the current one. It also covers the single pulse produced after a trigger.

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int CW = 16,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          trig,
  output logic          ch_out,
  output logic          cmp_evt,
  output logic          upd_evt
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_PSC  = AW'(1);
  localparam logic [AW-1:0] A_ARR  = AW'(2);
  localparam logic [AW-1:0] A_CCR  = AW'(3);
  localparam logic [2:0] M_FRZ = 3'd0, M_SET = 3'd1, M_CLR = 3'd2, M_TGL = 3'd3,
                         M_PWA = 3'd6, M_PWB = 3'd7;

  logic          en, opm, op_run, oc_pin;
  logic [2:0]    mode;
  logic [CW-1:0] psc_pre, arr_pre, ccr_pre;
  logic [CW-1:0] psc_act, arr_act, ccr_act;
  logic [CW-1:0] pc, cnt;

  logic          running, tick, wrap, hit;
  logic [CW-1:0] cnt_nx, ccr_nx;

  assign running = en & (~opm | op_run);
  assign tick    = running & (pc == psc_act);
  assign wrap    = tick & (cnt == arr_act);
  assign cnt_nx  = wrap ? '0 : CW'(cnt + 1'b1);
  assign ccr_nx  = wrap ? ccr_pre : ccr_act;
  assign hit     = tick & (cnt_nx == ccr_nx);

  always_comb begin
    unique case (mode)
      M_PWA:   ch_out = en & (cnt < ccr_act);
      M_PWB:   ch_out = en & (cnt >= ccr_act);
      default: ch_out = en & oc_pin;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      opm     <= 1'b0;
      mode    <= M_FRZ;
      psc_pre <= '0;
      arr_pre <= '1;
      ccr_pre <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        A_CTRL: begin
          en   <= wr_data[0];
          mode <= wr_data[3:1];
          opm  <= wr_data[4];
        end
        A_PSC:   psc_pre <= wr_data;
        A_ARR:   arr_pre <= wr_data;
        A_CCR:   ccr_pre <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_act <= '0;
      arr_act <= '1;
      ccr_act <= '0;
    end else if (!running || wrap) begin
      psc_act <= psc_pre;
      arr_act <= arr_pre;
      ccr_act <= ccr_pre;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      pc  <= '0;
    end else if (!running) begin
      cnt <= '0;
      pc  <= '0;
    end else if (tick) begin
      cnt <= cnt_nx;
      pc  <= '0;
    end else begin
      pc  <= CW'(pc + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      op_run <= 1'b0;
    else if (!en || !opm || wrap)
      op_run <= 1'b0;
    else if (trig)
      op_run <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_pin  <= 1'b0;
      cmp_evt <= 1'b0;
      upd_evt <= 1'b0;
    end else begin
      cmp_evt <= hit;
      upd_evt <= wrap;
      if (!en)
        oc_pin <= 1'b0;
      else if (hit) begin
        unique case (mode)
          M_SET:   oc_pin <= 1'b1;
          M_CLR:   oc_pin <= 1'b0;
          M_TGL:   oc_pin <= ~oc_pin;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          opm,
  input logic          op_run,
  input logic [2:0]    mode,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] arr_act,
  input logic [CW-1:0] ccr_act,
  input logic          ch_out,
  input logic          cmp_evt,
  input logic          upd_evt
);
  // R1
  upd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |-> cnt == '0);

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= arr_act);

  // R7
  cmp_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |-> cnt == ccr_act);

  // R2
  pwm_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 3'd6 && $past(en && mode == 3'd6) && $rose(ch_out)) |-> cnt == '0);

  // R5
  set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 3'd1 && $past(en && mode == 3'd1)) |-> !$fell(ch_out));

  // R6
  frozen_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == 3'd0 && $past(en && mode == 3'd0)) |-> $stable(ch_out));

  // R9
  oneshot_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && opm && !op_run && $past(en && opm && !op_run)) |-> (cnt == '0 && !upd_evt));
endmodule

bind cmp_timer cmp_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .opm(opm), .op_run(op_run), .mode(mode),
  .cnt(cnt), .arr_act(arr_act), .ccr_act(ccr_act), .ch_out(ch_out),
  .cmp_evt(cmp_evt), .upd_evt(upd_evt)
);

// File: tb/sim_cmp_timer.sv
module sim_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        trig = 1'b0;
  logic        ch_out, cmp_evt, upd_evt;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cmp_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                .wr_data(wr_data), .trig(trig), .ch_out(ch_out),
                .cmp_evt(cmp_evt), .upd_evt(upd_evt));

  typedef struct packed {
    logic [2:0]  mode;
    logic [15:0] psc;
    logic [15:0] arr;
    logic [15:0] ccr;
    int          hi;
    int          ncmp;
    int          nupd;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{3'd6, 16'd0, 16'd9, 16'd3,  12, 4, 3},  // R2
    '{3'd6, 16'd2, 16'd4, 16'd2,  24, 4, 3},  // R2 with prescaler
    '{3'd6, 16'd0, 16'd7, 16'd12, 32, 0, 3},  // R2 compare above reload
    '{3'd6, 16'd0, 16'd7, 16'd0,   0, 3, 3},  // R2 compare zero
    '{3'd7, 16'd0, 16'd9, 16'd3,  28, 4, 3},  // R3
    '{3'd7, 16'd1, 16'd5, 16'd5,   8, 4, 3},  // R3
    '{3'd3, 16'd0, 16'd9, 16'd4,  20, 4, 3},  // R4
    '{3'd3, 16'd3, 16'd3, 16'd1,  32, 4, 3},  // R4
    '{3'd1, 16'd0, 16'd9, 16'd6,  34, 4, 3},  // R5
    '{3'd2, 16'd0, 16'd9, 16'd6,   0, 4, 3},  // R5
    '{3'd0, 16'd0, 16'd9, 16'd5,   0, 4, 3},  // R6
    '{3'd0, 16'd2, 16'd3, 16'd3,   0, 4, 3}   // R6
  };

  function automatic string mode_req(logic [2:0] m);
    case (m)
      3'd6:         return "R2";
      3'd7:         return "R3";
      3'd3:         return "R4";
      3'd1, 3'd2:   return "R5";
      default:      return "R6";
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_addr = a;
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int hi, nc, nu;
    repeat (3) @(negedge clk);
    // R10 values during reset
    chk("R10 ch_out in reset", ch_out, 0);
    chk("R10 cmp_evt in reset", cmp_evt, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 ch_out after reset", ch_out, 0);
    chk("R10 upd_evt after reset", upd_evt, 0);

    for (int v = 0; v < NV; v++) begin
      int win;
      wr(2'd0, 16'd0);
      wr(2'd1, VEC[v].psc);
      wr(2'd2, VEC[v].arr);
      wr(2'd3, VEC[v].ccr);
      wr(2'd0, 16'(1 | (VEC[v].mode << 1)));
      win = 4 * (int'(VEC[v].arr) + 1) * (int'(VEC[v].psc) + 1);
      hi = 0; nc = 0; nu = 0;
      for (int k = 0; k < win; k++) begin
        hi += ch_out;
        nc += cmp_evt;
        nu += upd_evt;
        @(negedge clk);
      end
      chk($sformatf("%s vec%0d high cycles", mode_req(VEC[v].mode), v), hi, VEC[v].hi);
      chk($sformatf("R7 vec%0d match strobes", v), nc, VEC[v].ncmp);
      chk($sformatf("R1 vec%0d wrap strobes", v), nu, VEC[v].nupd);
    end

    // R10 disabling forces the pin low
    wr(2'd0, 16'd0);
    chk("R10 pin low when disabled", ch_out, 0);

    // R5 pin holds across mode change until next match
    wr(2'd1, 16'd0);
    wr(2'd2, 16'd9);
    wr(2'd3, 16'd6);
    wr(2'd0, 16'(1 | (1 << 1)));
    while (!ch_out) @(negedge clk);
    do @(negedge clk); while (!upd_evt);
    wr(2'd0, 16'(1 | (2 << 1)));
    chk("R5 pin held after mode change", ch_out, 1);
    while (!cmp_evt) @(negedge clk);
    chk("R5 pin cleared on match", ch_out, 0);

    // R8 compare write while running is deferred to the wrap
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd0);
    wr(2'd2, 16'd9);
    wr(2'd3, 16'd3);
    wr(2'd0, 16'(1 | (6 << 1)));
    do @(negedge clk); while (!upd_evt);
    repeat (4) @(negedge clk);
    wr(2'd3, 16'd8);
    for (int k = 0; k < 5; k++) begin
      chk($sformatf("R8 old compare kept k=%0d", k), ch_out, 0);
      @(negedge clk);
    end
    chk("R8 wrap after deferred write", upd_evt, 1);
    hi = 0;
    for (int k = 0; k < 10; k++) begin
      hi += ch_out;
      @(negedge clk);
    end
    chk("R8 new compare in next period", hi, 8);

    // R9 one-shot pulse
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd0);
    wr(2'd2, 16'd9);
    wr(2'd3, 16'd4);
    wr(2'd0, 16'(1 | (7 << 1) | (1 << 4)));
    hi = 0; nu = 0; nc = 0;
    for (int k = 0; k < 20; k++) begin
      hi += ch_out; nu += upd_evt; nc += cmp_evt;
      @(negedge clk);
    end
    chk("R9 idle before trigger high", hi, 0);
    chk("R9 idle before trigger strobes", nu + nc, 0);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    hi = 0; nu = 0; nc = 0;
    for (int k = 0; k < 40; k++) begin
      hi += ch_out; nu += upd_evt; nc += cmp_evt;
      @(negedge clk);
    end
    chk("R9 pulse width", hi, 6);
    chk("R9 single wrap", nu, 1);
    chk("R7 single match in one-shot", nc, 1);
    chk("R9 halted pin low", ch_out, 0);

    finish_run();
  end
endmodule